// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a clocked monostable pulse generator. A qualifying edge on one of its two trigger inputs drives the output high for a programmed number of clock cycles. The rising-edge trigger and the falling-edge trigger gate each other. A rising edge on the positive trigger counts only while the negative trigger is high. A falling edge on the negative trigger counts only while the positive trigger is low.

A mode input chooses how the block treats triggers that arrive while a pulse is running. In retriggerable mode such a trigger restarts the period. In non-retriggerable mode it is ignored. An active-low reset clears the pulse at once and holds the block idle.

Both trigger inputs are asynchronous. Each passes through a synchronizer, so the delay from a trigger to the output is a fixed number of cycles and does not depend on the period. The output comes as a true and complementary pair.

Top module: `oneshot_timer`

## Requirements
- R1: A rising edge on `trig_pos_i` starts a pulse only while `trig_neg_i` is high. With `trig_neg_i` low, that edge produces no pulse.
- R2: A falling edge on `trig_neg_i` starts a pulse only while `trig_pos_i` is low. With `trig_pos_i` high, that edge produces no pulse.
- R3: With `retrig_i` = 1, a qualifying trigger during an active pulse restarts the timer. `q_o` then falls `period_i` cycles after that latest trigger takes effect.
- R4: While `rst_n` is low, `q_o` is low. Reset clears a running pulse without waiting for a clock edge, and no trigger starts a pulse while reset stays low.
- R5: `q_n_o` is the logical complement of `q_o` at every sampled cycle.
- R6: With `retrig_i` = 0, qualifying triggers during an active pulse are ignored, and the pulse lasts exactly one period.
- R7: `q_o` rises at the third rising clock edge after a trigger input changes. Synchronizer depth is 2. This latency is the same for every period value.
- R8: `q_o` stays high for exactly `period_i` clock cycles. A trigger that arrives while `period_i` = 0 has no effect: it neither starts nor restarts a pulse.
- R9: After `rst_n` rises, a trigger condition that is already present at the first clock edge after release does not fire. `q_o` stays low until a new qualifying edge arrives.
- R10: `period_i` is sampled when the trigger takes effect. Changing it during a pulse does not alter that pulse's length.
- R11: If reset is asserted after a trigger edge but before the pulse has started, the pending pulse is cancelled, and the held trigger level does not start one after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the pulse immediately |
| trig_pos_i | input | 1 | Asynchronous trigger, active on its rising edge |
| trig_neg_i | input | 1 | Asynchronous trigger, active on its falling edge |
| period_i | input | PERIOD_W | Pulse length in clock cycles; 0 suppresses pulses |
| retrig_i | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| q_o | output | 1 | Pulse output |
| q_n_o | output | 1 | Complement of `q_o` |

## Verification
Periods 0 through 6 are swept for each trigger input in each mode. Each run measures the start cycle and the width of the pulse, which separates the fixed latency from the programmed length and covers the zero-period suppression. In a pair of overlapping-trigger runs, the only change is the mode input, so they tell retrigger extension apart from ignoring the later trigger. Gating, reset, and period-change scenarios each hold a trigger level steady across the event under test. This shows whether a held level is wrongly taken for an edge.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic {
    OS_SINGLE = 1'b0,
    OS_RETRIG = 1'b1
  } os_mode_e;

  // Cycles from a trigger input change to the output transition.
  function automatic int unsigned trig_latency(int unsigned stages);
    return stages + 1;
  endfunction

  // Clock edges after reset release before edge detection is trusted.
  function automatic int unsigned settle_cycles(int unsigned stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/os_edge_sync.sv
module os_edge_sync
  import oneshot_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned SETTLE = settle_cycles(STAGES);
  localparam int unsigned SW     = $clog2(SETTLE + 1);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic [SW-1:0]     settle_q;
  logic              settled;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      settle_q <= '0;
    end else begin
      prev_q <= chain_q[STAGES-1];
      if (!settled) settle_q <= settle_q + SW'(1);
    end
  end

  assign settled = (settle_q == SW'(SETTLE));
  assign lvl_o   = chain_q[STAGES-1];
  assign rise_o  = settled &  lvl_o & ~prev_q;
  assign fall_o  = settled & ~lvl_o &  prev_q;

endmodule

// File: rtl/os_trigger_qual.sv
module os_trigger_qual (
  input  logic [1:0] lvl_i,
  input  logic [1:0] rise_i,
  input  logic [1:0] fall_i,
  output logic       fire_pos_o,
  output logic       fire_neg_o,
  output logic       fire_o
);

  // Index 0 carries the positive trigger, index 1 the negative trigger.
  assign fire_pos_o = rise_i[0] &  lvl_i[1];
  assign fire_neg_o = fall_i[1] & ~lvl_i[0];
  assign fire_o     = fire_pos_o | fire_neg_o;

endmodule

// File: rtl/os_period_timer.sv
module os_period_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire_i,
  input  os_mode_e     mode_i,
  input  logic [W-1:0] period_i,
  output logic         active_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  function automatic logic [W-1:0] next_count(
    input logic [W-1:0] cur,
    input logic         fire,
    input logic         retrig,
    input logic [W-1:0] per
  );
    if (fire && (per != '0) && (retrig || (cur == '0))) return per;
    if (cur != '0) return cur - ONE;
    return '0;
  endfunction

  assign cnt_d = next_count(cnt_q, fire_i, mode_i == OS_RETRIG, period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (cnt_q == '0); // R4
    end
  end

  AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && mode_i == OS_RETRIG && period_i != '0) |=> (cnt_q == $past(period_i))); // R3

  AST_SINGLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && mode_i == OS_SINGLE && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE)); // R6

  AST_START_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(fire_i)); // R1

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !fire_i) |=> (cnt_q == $past(cnt_q) - ONE)); // R8

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned PERIOD_W    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_pos_i,
  input  logic                trig_neg_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                retrig_i,
  output logic                q_o,
  output logic                q_n_o
);

  localparam int unsigned NTRIG = 2;

  logic [NTRIG-1:0] trig_raw;
  logic [NTRIG-1:0] trig_lvl;
  logic [NTRIG-1:0] trig_rise;
  logic [NTRIG-1:0] trig_fall;
  logic             fire_pos;
  logic             fire_neg;
  logic             fire;
  logic             active;

  assign trig_raw = {trig_neg_i, trig_pos_i};

  genvar gi;
  generate
    for (gi = 0; gi < NTRIG; gi++) begin : g_sync
      os_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (trig_raw[gi]),
        .lvl_o  (trig_lvl[gi]),
        .rise_o (trig_rise[gi]),
        .fall_o (trig_fall[gi])
      );
    end
  endgenerate

  os_trigger_qual u_qual (
    .lvl_i      (trig_lvl),
    .rise_i     (trig_rise),
    .fall_i     (trig_fall),
    .fire_pos_o (fire_pos),
    .fire_neg_o (fire_neg),
    .fire_o     (fire)
  );

  os_period_timer #(.W(PERIOD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (fire),
    .mode_i   (os_mode_e'(retrig_i)),
    .period_i (period_i),
    .active_o (active)
  );

  assign q_o   = active;
  assign q_n_o = ~active;

  AST_POS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fire_pos |-> trig_lvl[1]); // R1

  AST_NEG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fire_neg |-> !trig_lvl[0]); // R2

endmodule

// File: tb/oneshot_timer_test.sv
module oneshot_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_pos = 1'b0;
  logic          trig_neg = 1'b1;
  logic [PW-1:0] period = '0;
  logic          retrig = 1'b0;
  logic          q, q_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int idx = 0;
  int first = -1;
  int width = 0;
  int pair_bad = 0;

  oneshot_timer #(.PERIOD_W(PW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .trig_pos_i(trig_pos), .trig_neg_i(trig_neg),
    .period_i(period), .retrig_i(retrig), .q_o(q), .q_n_o(q_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor samples 3 time units after each rising edge.
  always @(posedge clk) begin
    #3;
    idx = idx + 1;
    if (q_n !== ~q) pair_bad = pair_bad + 1;
    if (q === 1'b1) begin
      if (first < 0) first = idx;
      width = width + 1;
    end
  end

  task automatic clear_mon();
    idx = 0; first = -1; width = 0; pair_bad = 0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One pulse through the chosen trigger input; src 0 = positive, 1 = negative.
  task automatic sweep_one(input int src, input int p, input bit mode);
    period = PW'(p);
    retrig = mode;
    if (src == 0) trig_pos = 1'b1; else trig_neg = 1'b0;
    clear_mon();
    step(p + 6);
    if (p == 0) begin
      check(width == 0, "R8 zero period", width, 0);
    end else begin
      check(first == LAT, "R7 latency", first, LAT);
      check(width == p, "R8 width", width, p);
    end
    check(pair_bad == 0, "R5 complement", pair_bad, 0);
    if (src == 0) trig_pos = 1'b0; else trig_neg = 1'b1;
    step(4);
  endtask

  task automatic overlap(input bit mode, input int exp_w, input string req);
    period = PW'(5);
    retrig = mode;
    trig_pos = 1'b1;
    clear_mon();
    step(2);
    trig_pos = 1'b0;
    step(2);
    trig_pos = 1'b1;
    step(14);
    check(first == LAT, req, first, LAT);
    check(width == exp_w, req, width, exp_w);
    trig_pos = 1'b0;
    step(4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(5);
    check(q == 1'b0 && q_n == 1'b1, "R4 reset state", q, 0);
    rst_n = 1'b1;
    step(6);

    // Period sweep for both inputs and both modes (R7, R8, R5)
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p <= 6; p++)
          sweep_one(s, p, m[0]);

    // R1: positive edge while negative trigger low
    period = '0; trig_neg = 1'b0; step(6);
    period = PW'(4); trig_pos = 1'b1; clear_mon(); step(10);
    check(width == 0, "R1 gated positive edge", width, 0);
    trig_pos = 1'b0; step(6);
    period = '0; trig_neg = 1'b1; step(6);

    // R2: negative edge while positive trigger high
    trig_pos = 1'b1; step(6);
    period = PW'(4); trig_neg = 1'b0; clear_mon(); step(10);
    check(width == 0, "R2 gated negative edge", width, 0);
    trig_pos = 1'b0; step(2); trig_neg = 1'b1; step(6);

    // R3 / R6: overlapping triggers
    overlap(1'b1, 9, "R3 retrigger extension");
    overlap(1'b0, 5, "R6 single ignores retrigger");

    // R10: period change mid-pulse
    period = PW'(4); retrig = 1'b1; trig_pos = 1'b1; clear_mon();
    step(4);
    period = PW'(9);
    step(12);
    check(width == 4, "R10 period sampled at trigger", width, 4);
    trig_pos = 1'b0; step(4);

    // R4: immediate clear and blocking during reset
    period = PW'(20); trig_pos = 1'b1; step(6);
    check(q == 1'b1, "R4 pulse running before reset", q, 1);
    #2 rst_n = 1'b0;
    #1 check(q == 1'b0 && q_n == 1'b1, "R4 immediate clear", q, 0);
    step(1);
    trig_pos = 1'b0; step(3); trig_pos = 1'b1; clear_mon(); step(6);
    check(width == 0, "R4 no pulse while in reset", width, 0);

    // R9: pre-existing condition at release
    period = PW'(4);
    rst_n = 1'b1; clear_mon(); step(12);
    check(width == 0, "R9 held level after release", width, 0);
    trig_pos = 1'b0; step(4);
    trig_pos = 1'b1; clear_mon(); step(10);
    check(first == LAT && width == 4, "R9 fresh edge after release", width, 4);
    trig_pos = 1'b0; step(4);

    // R11: reset inside latency window cancels pending pulse
    trig_pos = 1'b1; clear_mon(); step(2);
    #2 rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(12);
    check(width == 0, "R11 pending pulse cancelled", width, 0);
    trig_pos = 1'b0; step(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule